// File: doc/BRIEF.md
# Line-Locked Acquisition Window Decimator

This block sits in a video inset path between the sampled Y, U and V components and a downstream memory writer. Its sample clock is locked to the horizontal sync and runs at 1792 clocks per line, so the sample position within a line can be counted directly. At each rising edge of horizontal sync the block restarts that count and captures a programmable fine offset. It adds the offset to a fixed system constant to get the position of the first kept sample.

From that position it keeps a run of at most 1408 consecutive samples. It halves them horizontally by averaging each adjacent pair, so a complete line gives 704 output pixels. The output is a valid-qualified stream with a line-start marker and a frame-start marker for the writer. If the window would run past the last position of the line, acquisition stops at the line end and a status output reports the line as short.

Top module: `acq_window_decimator`

## Requirements
- R1: A rising edge on `hsync` (high now, low on the previous clock) marks the sample presented in that same clock as position 0. Later samples take positions 1, 2, and so on, up to position 1791, which is the last position of a line.
- R2: The first kept sample of a line is at position 96 + `fine_pos`. `fine_pos` is captured only in the clock of the `hsync` rising edge, so a change later in the line has no effect until the next line.
- R3: At most 1408 samples are kept per line. A line whose window fits inside positions 0..1791 gives exactly 704 output pixels.
- R4: Kept samples form pairs in order, starting with the first kept sample of the line. For each pair the block outputs one pixel per component equal to (first + second + 1) >> 1 (Y, U and V are each 8 bits). `pix_valid` is high for one clock, in the clock after the second sample of the pair.
- R5: `pix_line_start` is high together with `pix_valid` on the first output pixel of each line and is low on every other clock.
- R6: A rising edge on `vsync` sets a pending flag. The next `hsync` rising edge passes the flag to its line, including an `hsync` edge in the same clock as the `vsync` edge. `pix_frame_start` is then high with that line's first output pixel.
- R7: When 96 + `fine_pos` + 1408 exceeds 1792, acquisition ends at position 1791 and an unpaired last sample is dropped. In the clock after position 1791, `line_short` is updated: 1 if fewer than 1408 samples were kept on that line, 0 otherwise.
- R8: After reset, `pix_valid`, `pix_line_start`, `pix_frame_start` and `line_short` are 0, and no pixel is produced until the first `hsync` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock, 1792 clocks per line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| fine_pos | input | 9 | Fine window offset, added to the system constant 96 |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | U chroma sample |
| in_v | input | 8 | V chroma sample |
| pix_valid | output | 1 | Output pixel strobe |
| pix_y | output | 8 | Averaged luma |
| pix_u | output | 8 | Averaged U |
| pix_v | output | 8 | Averaged V |
| pix_line_start | output | 1 | First output pixel of a line |
| pix_frame_start | output | 1 | First output pixel of the first line after vertical sync |
| line_short | output | 1 | Last completed line kept fewer than 1408 samples |

## Verification
The bench targets window placements at the line boundary. Start 384 fills the line exactly and must not be flagged short. Start 385 loses one sample, so it yields 703 pixels and sets the short flag. Starts that leave an odd sample count test that the unpaired last sample is dropped rather than averaged with garbage. Two more cases stress the line's latched settings. Changing `fine_pos` in mid-line exposes a design that re-reads the offset, which would place the window wrongly. A `vsync` edge in mid-line must flag the next line only, and one that coincides with the `hsync` edge must flag the current line; a design that handles either wrongly puts the frame marker on the wrong line or drops it.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int COMP_W   = 8;
  localparam int NUM_COMP = 3;
  localparam int CY = 0;
  localparam int CU = 1;
  localparam int CV = 2;
  typedef logic [NUM_COMP-1:0][COMP_W-1:0] pix_t;
endpackage

// File: rtl/acq_line_timer.sv
module acq_line_timer #(
  parameter int LINE_LEN   = 1792,
  parameter int ACQ_LEN    = 1408,
  parameter int SYS_OFFSET = 96,
  parameter int FINE_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [FINE_W-1:0] fine_pos,
  output logic              acq_en,
  output logic              acq_first,
  output logic              line_frame,
  output logic              line_short
);
  localparam int POS_W = $clog2(LINE_LEN);
  localparam int SUM_W = $clog2(SYS_OFFSET + (1 << FINE_W));
  localparam int CMP_W = (POS_W > SUM_W) ? POS_W : SUM_W;
  localparam int TAK_W = $clog2(ACQ_LEN + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_LEN - 1);
  localparam logic [TAK_W-1:0] ACQ_MAX  = TAK_W'(ACQ_LEN);

  // registered state
  logic             hs_q, vs_q, act_q, pend_q, frame_q, short_q;
  logic [POS_W-1:0] pos_q;
  logic [SUM_W-1:0] start_q;
  logic [TAK_W-1:0] taken_q;

  // next-state
  logic             hs_d, vs_d, act_d, pend_d, frame_d, short_d;
  logic [POS_W-1:0] pos_d;
  logic [SUM_W-1:0] start_d;
  logic [TAK_W-1:0] taken_d;

  // current-sample view
  logic             hs_rise, vs_rise, cur_act, line_end, close_evt;
  logic [POS_W-1:0] cur_pos;
  logic [SUM_W-1:0] fine_sum, cur_start;
  logic [TAK_W-1:0] cur_taken;

  always_comb begin
    hs_rise   = hsync & ~hs_q;
    vs_rise   = vsync & ~vs_q;
    fine_sum  = SUM_W'(SYS_OFFSET) + SUM_W'(fine_pos);
    cur_pos   = hs_rise ? '0 : pos_q;
    cur_start = hs_rise ? fine_sum : start_q;
    cur_act   = hs_rise | act_q;
    cur_taken = hs_rise ? '0 : taken_q;

    acq_en    = cur_act && (CMP_W'(cur_pos) >= CMP_W'(cur_start)) && (cur_taken < ACQ_MAX);
    acq_first = acq_en && (cur_taken == '0);
    line_end  = cur_act && (cur_pos == LAST_POS);
    // a line also closes if a new sync cuts it before its last position
    close_evt = line_end | (hs_rise & act_q);

    hs_d    = hsync;
    vs_d    = vsync;
    pos_d   = (cur_pos == LAST_POS) ? cur_pos : cur_pos + POS_W'(1);
    start_d = cur_start;
    taken_d = cur_taken + {{(TAK_W-1){1'b0}}, acq_en};
    act_d   = cur_act & ~line_end;

    pend_d  = pend_q;
    frame_d = frame_q;
    if (hs_rise) begin
      frame_d = pend_q | vs_rise;
      pend_d  = 1'b0;
    end else if (vs_rise) begin
      pend_d  = 1'b1;
    end
    line_frame = hs_rise ? (pend_q | vs_rise) : frame_q;

    short_d = short_q;
    if (line_end)
      short_d = (taken_d < ACQ_MAX);
    else if (hs_rise & act_q)
      short_d = (taken_q < ACQ_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      frame_q <= 1'b0;
      short_q <= 1'b0;
      pos_q   <= '0;
      start_q <= '0;
      taken_q <= '0;
    end else begin
      hs_q    <= hs_d;
      vs_q    <= vs_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      frame_q <= frame_d;
      short_q <= short_d;
      pos_q   <= pos_d;
      start_q <= start_d;
      taken_q <= taken_d;
    end
  end

  assign line_short = short_q;

  // position restarts on a sync edge
  assert_pos_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (pos_q == POS_W'(1)));

  // the first kept sample sits exactly on the latched start
  assert_first_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_first |-> (CMP_W'(cur_pos) == CMP_W'(cur_start)));

  // never more than the window length kept
  assert_take_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= ACQ_MAX);

  // short status moves only when a line closes
  assert_short_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q != $past(short_q)) |-> $past(close_evt));
endmodule

// File: rtl/acq_pair_reducer.sv
module acq_pair_reducer
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic acq_first,
  input  logic line_frame,
  input  pix_t pix_in,
  output logic out_valid,
  output pix_t pix_out,
  output logic out_ls,
  output logic out_fs
);
  logic phase_q, lead_q, fsp_q, valid_q, ls_q, fs_q;
  logic phase_d, lead_d, fsp_d, valid_d, ls_d, fs_d;
  pix_t held_q, held_d, avg_q, avg_d, avg_w;
  logic cur_phase, pair_done, held_en;

  // one rounding averager per component
  genvar c;
  generate
    for (c = 0; c < NUM_COMP; c++) begin : g_avg
      logic [COMP_W:0] sum_w;
      assign sum_w    = {1'b0, held_q[c]} + {1'b0, pix_in[c]} + {{COMP_W{1'b0}}, 1'b1};
      assign avg_w[c] = sum_w[COMP_W:1];
    end
  endgenerate

  always_comb begin
    cur_phase = acq_first ? 1'b0 : phase_q;
    pair_done = acq_en & cur_phase;
    held_en   = acq_en & ~cur_phase;

    phase_d = acq_en ? ~cur_phase : phase_q;
    held_d  = held_en ? pix_in : held_q;

    lead_d = lead_q;
    fsp_d  = fsp_q;
    if (acq_first) begin
      lead_d = 1'b1;
      fsp_d  = line_frame;
    end else if (pair_done) begin
      lead_d = 1'b0;
      fsp_d  = 1'b0;
    end

    valid_d = pair_done;
    ls_d    = pair_done & lead_q;
    fs_d    = pair_done & lead_q & fsp_q;
    avg_d   = pair_done ? avg_w : avg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      fsp_q   <= 1'b0;
      valid_q <= 1'b0;
      ls_q    <= 1'b0;
      fs_q    <= 1'b0;
      held_q  <= '0;
      avg_q   <= '0;
    end else begin
      phase_q <= phase_d;
      lead_q  <= lead_d;
      fsp_q   <= fsp_d;
      valid_q <= valid_d;
      ls_q    <= ls_d;
      fs_q    <= fs_d;
      held_q  <= held_d;
      avg_q   <= avg_d;
    end
  end

  assign out_valid = valid_q;
  assign pix_out   = avg_q;
  assign out_ls    = ls_q;
  assign out_fs    = fs_q;

  // a pixel needs two samples, so strobes never touch
  assert_pair_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_ls_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ls |-> out_valid);

  assert_fs_on_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fs |-> out_ls);
endmodule

// File: rtl/acq_window_decimator.sv
module acq_window_decimator
  import acq_pkg::*;
#(
  parameter int LINE_LEN   = 1792,
  parameter int ACQ_LEN    = 1408,
  parameter int SYS_OFFSET = 96,
  parameter int FINE_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [FINE_W-1:0] fine_pos,
  input  logic [COMP_W-1:0] in_y,
  input  logic [COMP_W-1:0] in_u,
  input  logic [COMP_W-1:0] in_v,
  output logic              pix_valid,
  output logic [COMP_W-1:0] pix_y,
  output logic [COMP_W-1:0] pix_u,
  output logic [COMP_W-1:0] pix_v,
  output logic              pix_line_start,
  output logic              pix_frame_start,
  output logic              line_short
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic acq_en, acq_first, line_frame;
  pix_t pix_in, pix_out;

  always_comb begin
    pix_in     = '0;
    pix_in[CY] = in_y;
    pix_in[CU] = in_u;
    pix_in[CV] = in_v;
  end

  acq_line_timer #(
    .LINE_LEN  (LINE_LEN),
    .ACQ_LEN   (ACQ_LEN),
    .SYS_OFFSET(SYS_OFFSET),
    .FINE_W    (FINE_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .hsync     (hsync),
    .vsync     (vsync),
    .fine_pos  (fine_pos),
    .acq_en    (acq_en),
    .acq_first (acq_first),
    .line_frame(line_frame),
    .line_short(line_short)
  );

  acq_pair_reducer u_reduce (
    .clk       (clk),
    .rst_n     (rst_sn),
    .acq_en    (acq_en),
    .acq_first (acq_first),
    .line_frame(line_frame),
    .pix_in    (pix_in),
    .out_valid (pix_valid),
    .pix_out   (pix_out),
    .out_ls    (pix_line_start),
    .out_fs    (pix_frame_start)
  );

  assign pix_y = pix_out[CY];
  assign pix_u = pix_out[CU];
  assign pix_v = pix_out[CV];
endmodule

// File: tb/acq_window_decimator_test.sv
`timescale 1ns/1ps
module acq_window_decimator_test;
  localparam int LINE = 1792;
  localparam int ACQ  = 1408;
  localparam int SYS  = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync, vsync;
  logic [8:0] fine_pos;
  logic [7:0] in_y, in_u, in_v;
  logic       pix_valid, pix_line_start, pix_frame_start, line_short;
  logic [7:0] pix_y, pix_u, pix_v;

  always #2 clk = ~clk;

  acq_window_decimator uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .fine_pos(fine_pos),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .pix_valid(pix_valid), .pix_y(pix_y), .pix_u(pix_u), .pix_v(pix_v),
    .pix_line_start(pix_line_start), .pix_frame_start(pix_frame_start),
    .line_short(line_short)
  );

  typedef struct {
    logic [7:0] y, u, v;
    bit ls, fs;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int checks = 0, failures = 0, got_cnt = 0;
  bit mon_on = 0, pend = 0, finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] sy(int ln, int p); return 8'((p * 7 + ln * 13) & 255); endfunction
  function automatic logic [7:0] su(int ln, int p); return 8'(((p * 3) ^ ln) & 255); endfunction
  function automatic logic [7:0] sv(int ln, int p); return 8'(255 - (p & 255)); endfunction
  function automatic logic [7:0] av(logic [7:0] a, logic [7:0] b);
    return 8'((int'(a) + int'(b) + 1) >> 1);
  endfunction

  // monitor: pops expected pixels as the design emits them
  always @(negedge clk) begin
    if (mon_on && pix_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected pixel", 1, 0);
      end else begin
        e = exp_q.pop_front();
        got_cnt++;
        chk(pix_y == e.y, "R4", "pix_y", pix_y, e.y);
        chk(pix_u == e.u, "R4", "pix_u", pix_u, e.u);
        chk(pix_v == e.v, "R4", "pix_v", pix_v, e.v);
        chk(pix_line_start == e.ls, "R5", "line_start", pix_line_start, e.ls);
        chk(pix_frame_start == e.fs, "R6", "frame_start", pix_frame_start, e.fs);
      end
    end else if (mon_on) begin
      chk(!pix_line_start && !pix_frame_start, "R5", "marker without valid",
          pix_line_start, 0);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync = 1'b0; vsync = 1'b0;
      in_y = 8'(i * 11); in_u = 8'(i); in_v = 8'(200 - i);
    end
  endtask

  // driver: one line with fine offset f (fm after position 40), vsync rising at vs
  task automatic drive_line(int ln, int f, int fm, int vs);
    int start, endp, n, lf;
    bit sh;
    if (vs == 0) pend = 1;
    lf = pend; pend = 0;
    start = SYS + f;
    endp = (start + ACQ > LINE) ? LINE : start + ACQ;
    n = endp - start;
    sh = (n < ACQ);
    for (int k = 0; k < n / 2; k++) begin
      exp_t x;
      int p;
      p = start + 2 * k;
      x.y = av(sy(ln, p), sy(ln, p + 1));
      x.u = av(su(ln, p), su(ln, p + 1));
      x.v = av(sv(ln, p), sv(ln, p + 1));
      x.ls = (k == 0);
      x.fs = (k == 0) && (lf != 0);
      exp_q.push_back(x);
    end
    if (vs > 0) pend = 1;
    got_cnt = 0;
    for (int p = 0; p < LINE; p++) begin
      @(negedge clk);
      hsync = (p < 64);
      vsync = (vs >= 0) && (p >= vs) && (p < vs + 100);
      fine_pos = 9'((p < 40) ? f : fm);
      in_y = sy(ln, p); in_u = su(ln, p); in_v = sv(ln, p);
    end
    @(posedge clk); #1;
    chk(line_short == sh, "R7", $sformatf("line_short line %0d", ln), line_short, sh);
    idle(4);
    chk(got_cnt == n / 2, "R3", $sformatf("pixels on line %0d", ln), got_cnt, n / 2);
    chk(exp_q.size() == 0, "R4", "pending expected pixels", exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; fine_pos = '0;
    in_y = '0; in_u = '0; in_v = '0;
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(!pix_valid, "R8", "valid in reset", pix_valid, 0);
    chk(!line_short, "R8", "short in reset", line_short, 0);
    chk(!pix_line_start && !pix_frame_start, "R8", "markers in reset", pix_line_start, 0);
    rst_n = 1'b1;
    mon_on = 1;
    // R8: no output before the first sync edge (monitor flags any pixel)
    idle(300);
    chk(!line_short, "R8", "short before first line", line_short, 0);
    drive_line(0, 0, 0, -1);      // full window at 96 (R1, R3, R4)
    drive_line(1, 17, 300, 500);  // mid-line offset change ignored (R2), vsync mid-line
    drive_line(2, 288, 5, -1);    // frame marker (R6), window ends on 1791 exactly
    drive_line(3, 289, 289, -1);  // one sample lost, short (R7)
    drive_line(4, 401, 401, 0);   // vsync with hsync edge (R6), odd count dropped (R7)
    drive_line(5, 511, 0, -1);    // largest offset, short (R7)
    drive_line(6, 3, 3, -1);      // full again clears short (R7)
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule